// File: doc/BRIEF.md
# Multifunction 32-bit ALU with Barrel Shifter

This block is the execute-stage arithmetic and logic unit of a small load/store processor. It takes two 32-bit operands, `opnd_a` and `opnd_b`, and a 5-bit immediate shift count. Eight control bits steer it, grouped into fixed fields: a 2-bit result class, an add/subtract bit, a shift-count source bit, a 2-bit shift operation and a 2-bit bitwise operation. Four units work in parallel on every cycle: a barrel shifter, a ripple adder/subtractor, a set-on-less unit fed by the adder, and a bitwise logic unit. A four-way multiplexer, indexed by the result class, picks one of their outputs as the result.

The adder always runs, whatever the class. Its zero, signed-overflow and carry-out flags are reported on every cycle, so a branch compare can read the zero flag while the result port carries something else. The result and the three flags are captured in one output register. Each operation therefore shows at the ports one clock after its inputs, and an active-low reset clears the register.

Top module: `mfalu`

## Requirements
- R1: `fn_class` selects the result: 00 gives the shifter output, 01 the set-on-less value, 10 the adder output, 11 the bitwise logic output.
- R2: `logic_op` selects the bitwise function of `opnd_a` and `opnd_b`: 00 AND, 01 OR, 10 XOR, 11 NOR.
- R3: `shift_op` selects the operation applied to `opnd_b`: 00 passes it unchanged, 01 shifts left filling zeros, 10 shifts right filling zeros, 11 shifts right filling copies of bit 31. A count of 0 returns `opnd_b` unchanged for every operation.
- R4: `shamt_src` = 0 takes the shift count from `imm_shamt`. `shamt_src` = 1 takes it from `opnd_a[4:0]`.
- R5: `sub_en` = 0 makes the adder compute `opnd_a + opnd_b`. `sub_en` = 1 makes it compute `opnd_a - opnd_b`, by inverting `opnd_b` and forcing a carry-in of 1. The result keeps the low 32 bits.
- R6: The set-on-less result has bits 31..1 at zero. Its bit 0 is bit 31 of the adder output, which is `opnd_a - opnd_b` when `sub_en` = 1.
- R7: `zero_flag` is 1 exactly when all 32 bits of the adder output are 0.
- R8: `ovf_flag` is 1 exactly when the add or subtract overflows as a signed two's-complement operation. `carry_out` is the carry out of bit 31 of the adder, including the forced carry-in when subtracting.
- R9: Results and flags appear at the outputs one rising `clk` edge after the inputs are applied. While `rst_n` is 0, `result`, `zero_flag`, `ovf_flag` and `carry_out` are all 0.
- R10: The three flags follow the adder for every `fn_class`, including classes whose result does not come from the adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| opnd_a | input | 32 | First operand; its low 5 bits can supply the shift count |
| opnd_b | input | 32 | Second operand; the value that is shifted |
| imm_shamt | input | 5 | Immediate shift count |
| fn_class | input | 2 | Result class: 00 shift, 01 set-on-less, 10 arithmetic, 11 logic |
| sub_en | input | 1 | 1 selects subtraction in the adder |
| shamt_src | input | 1 | 0 takes the count from imm_shamt, 1 from opnd_a[4:0] |
| shift_op | input | 2 | 00 none, 01 left, 10 right logical, 11 right arithmetic |
| logic_op | input | 2 | 00 AND, 01 OR, 10 XOR, 11 NOR |
| result | output | 32 | Registered result |
| zero_flag | output | 1 | Registered: adder output is all zeros |
| ovf_flag | output | 1 | Registered: signed overflow of the adder |
| carry_out | output | 1 | Registered: carry out of bit 31 of the adder |

## Verification
The hardest cases to reach from the ports are the flag corners and the set-on-less overflow case. Signed overflow needs both operands near the signed limits with matching signs, and a subtraction that overflows sets bit 0 of the set-on-less result opposite to the true signed order. Random operands almost never land on either case, so the stimulus table pins the extremes 0x7FFFFFFF, 0x80000000, all-ones and equal operands. One entry sets the flags from a subtraction while the logic class drives the result, which shows the flags are independent of the result class. A random sweep against an operator-level model covers all control combinations, including variable counts taken from the first operand.

// File: rtl/mfalu_pkg.sv
package mfalu_pkg;

    localparam int DATA_W  = 32;
    localparam int SHAMT_W = $clog2(DATA_W);

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'b00,
        CLS_SLT   = 2'b01,
        CLS_ARITH = 2'b10,
        CLS_LOGIC = 2'b11
    } fn_class_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'b00,
        SH_LL   = 2'b01,
        SH_LR   = 2'b10,
        SH_AR   = 2'b11
    } shift_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'b00,
        LG_OR  = 2'b01,
        LG_XOR = 2'b10,
        LG_NOR = 2'b11
    } logic_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              zero;
        logic              ovf;
        logic              carry;
    } alu_out_t;

endpackage

// File: rtl/mfalu_addsub.sv
module mfalu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry_out,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   cy;

    assign b_eff = b ^ {W{sub}};
    assign cy[0] = sub;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p_i;
        assign p_i       = a[i] ^ b_eff[i];
        assign sum[i]    = p_i ^ cy[i];
        assign cy[i+1]   = (a[i] & b_eff[i]) | (cy[i] & p_i);
    end

    assign carry_out = cy[W];
    // signed overflow: carry into the sign bit differs from carry out of it
    assign ovf       = cy[W-1] ^ cy[W];
endmodule

// File: rtl/mfalu_shifter.sv
module mfalu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic [1:0]    op,
    output logic [W-1:0]  dout
);
    import mfalu_pkg::*;

    logic [W-1:0] stage [SW+1];
    logic         go_left;
    logic         active;
    logic         fill;

    always_comb begin
        go_left = (shift_op_e'(op) == SH_LL);
        active  = (shift_op_e'(op) != SH_NONE);
        fill    = (shift_op_e'(op) == SH_AR) ? din[W-1] : 1'b0;
    end

    assign stage[0] = din;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [W-1:0] left_v;
        logic [W-1:0] right_v;
        assign left_v   = {stage[k][W-1-D:0], {D{1'b0}}};
        assign right_v  = {{D{fill}}, stage[k][W-1:D]};
        assign stage[k+1] = (amt[k] && active) ? (go_left ? left_v : right_v)
                                               : stage[k];
    end

    assign dout = stage[SW];
endmodule

// File: rtl/mfalu_logic.sv
module mfalu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   op,
    output logic [W-1:0] y
);
    import mfalu_pkg::*;

    always_comb begin
        unique case (logic_op_e'(op))
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            LG_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mfalu.sv
module mfalu (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic [4:0]  imm_shamt,
    input  logic [1:0]  fn_class,
    input  logic        sub_en,
    input  logic        shamt_src,
    input  logic [1:0]  shift_op,
    input  logic [1:0]  logic_op,
    output logic [31:0] result,
    output logic        zero_flag,
    output logic        ovf_flag,
    output logic        carry_out
);
    import mfalu_pkg::*;

    localparam int W  = DATA_W;
    localparam int SW = SHAMT_W;

    logic [W-1:0]  add_y;
    logic          add_c;
    logic          add_v;
    logic [W-1:0]  sh_y;
    logic [W-1:0]  lg_y;
    logic [SW-1:0] shamt;

    alu_out_t out_d;
    alu_out_t out_q;

    // R4: count source
    assign shamt = shamt_src ? opnd_a[SW-1:0] : imm_shamt;

    mfalu_addsub #(.W(W)) u_addsub (
        .a         (opnd_a),
        .b         (opnd_b),
        .sub       (sub_en),
        .sum       (add_y),
        .carry_out (add_c),
        .ovf       (add_v)
    );

    mfalu_shifter #(.W(W), .SW(SW)) u_shift (
        .din  (opnd_b),
        .amt  (shamt),
        .op   (shift_op),
        .dout (sh_y)
    );

    mfalu_logic #(.W(W)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .op (logic_op),
        .y  (lg_y)
    );

    always_comb begin
        out_d       = '0;
        out_d.zero  = ~|add_y;
        out_d.ovf   = add_v;
        out_d.carry = add_c;
        unique case (fn_class_e'(fn_class))
            CLS_SHIFT: out_d.result = sh_y;
            CLS_SLT:   out_d.result = {{(W-1){1'b0}}, add_y[W-1]};
            CLS_ARITH: out_d.result = add_y;
            CLS_LOGIC: out_d.result = lg_y;
            default:   out_d.result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result    = out_q.result;
    assign zero_flag = out_q.zero;
    assign ovf_flag  = out_q.ovf;
    assign carry_out = out_q.carry;
endmodule

// File: rtl/mfalu_chk.sv
module mfalu_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [4:0]  imm_shamt,
    input logic [1:0]  fn_class,
    input logic        sub_en,
    input logic        shamt_src,
    input logic [1:0]  shift_op,
    input logic [1:0]  logic_op,
    input logic [31:0] result,
    input logic        zero_flag,
    input logic        ovf_flag,
    input logic        carry_out
);
    assert_and_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_class == 2'b11 && logic_op == 2'b00) |=> result == ($past(opnd_a) & $past(opnd_b)));

    assert_nor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_class == 2'b11 && logic_op == 2'b11) |=> result == ~($past(opnd_a) | $past(opnd_b)));

    assert_noshift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_class == 2'b00 && shift_op == 2'b00) |=> result == $past(opnd_b));

    assert_sra_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_class == 2'b00 && shift_op == 2'b11 && opnd_b[31]) |=> result[31]);

    assert_varcount_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_class == 2'b00 && shamt_src && opnd_a[4:0] == 5'd0) |=> result == $past(opnd_b));

    assert_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_class == 2'b10 && !sub_en) |=> result == $past(opnd_a) + $past(opnd_b));

    assert_slt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_class == 2'b01) |=> result[31:1] == 31'd0);

    assert_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_class == 2'b10) |=> zero_flag == (result == 32'd0));

    assert_no_ovf_mixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sub_en && opnd_a[31] != opnd_b[31]) |=> !ovf_flag);

    assert_sub_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_en && opnd_a == opnd_b) |=> (zero_flag && carry_out && !ovf_flag));
endmodule

bind mfalu mfalu_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .imm_shamt (imm_shamt),
    .fn_class  (fn_class),
    .sub_en    (sub_en),
    .shamt_src (shamt_src),
    .shift_op  (shift_op),
    .logic_op  (logic_op),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag),
    .carry_out (carry_out)
);

// File: tb/mfalu_test.sv
`timescale 1ns/1ps
module mfalu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  imm_shamt = '0;
    logic [1:0]  fn_class = '0;
    logic        sub_en = 1'b0;
    logic        shamt_src = 1'b0;
    logic [1:0]  shift_op = '0;
    logic [1:0]  logic_op = '0;
    logic [31:0] result;
    logic        zero_flag, ovf_flag, carry_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    mfalu uut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .imm_shamt(imm_shamt), .fn_class(fn_class), .sub_en(sub_en),
        .shamt_src(shamt_src), .shift_op(shift_op), .logic_op(logic_op),
        .result(result), .zero_flag(zero_flag), .ovf_flag(ovf_flag),
        .carry_out(carry_out)
    );

    typedef struct packed {
        logic [1:0]  cls;
        logic        sub;
        logic        src;
        logic [1:0]  sop;
        logic [1:0]  lop;
        logic [4:0]  imm;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp_y;
        logic        chk_f;
        logic        exp_z;
        logic        exp_v;
        logic        exp_c;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'b10,1'b0,1'b0,2'b00,2'b00,5'd0, 32'h5,        32'h3,        32'h8,        1'b1,1'b0,1'b0,1'b0},
        '{2'b10,1'b1,1'b0,2'b00,2'b00,5'd0, 32'h3,        32'h3,        32'h0,        1'b1,1'b1,1'b0,1'b1},
        '{2'b10,1'b0,1'b0,2'b00,2'b00,5'd0, 32'h7FFFFFFF, 32'h1,        32'h80000000, 1'b1,1'b0,1'b1,1'b0},
        '{2'b10,1'b1,1'b0,2'b00,2'b00,5'd0, 32'h80000000, 32'h1,        32'h7FFFFFFF, 1'b1,1'b0,1'b1,1'b1},
        '{2'b10,1'b0,1'b0,2'b00,2'b00,5'd0, 32'hFFFFFFFF, 32'h1,        32'h0,        1'b1,1'b1,1'b0,1'b1},
        '{2'b11,1'b0,1'b0,2'b00,2'b00,5'd0, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0,1'b0,1'b0,1'b0},
        '{2'b11,1'b0,1'b0,2'b00,2'b01,5'd0, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0, 1'b0,1'b0,1'b0,1'b0},
        '{2'b11,1'b0,1'b0,2'b00,2'b10,5'd0, 32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00F0F, 1'b0,1'b0,1'b0,1'b0},
        '{2'b11,1'b0,1'b0,2'b00,2'b11,5'd0, 32'h0,        32'h0,        32'hFFFFFFFF, 1'b1,1'b1,1'b0,1'b0},
        '{2'b11,1'b1,1'b0,2'b00,2'b00,5'd0, 32'h5,        32'h5,        32'h5,        1'b1,1'b1,1'b0,1'b1},
        '{2'b00,1'b0,1'b0,2'b01,2'b00,5'd31,32'h0,        32'h1,        32'h80000000, 1'b0,1'b0,1'b0,1'b0},
        '{2'b00,1'b0,1'b0,2'b10,2'b00,5'd4, 32'h0,        32'h80000000, 32'h08000000, 1'b0,1'b0,1'b0,1'b0},
        '{2'b00,1'b0,1'b0,2'b11,2'b00,5'd4, 32'h0,        32'h80000000, 32'hF8000000, 1'b0,1'b0,1'b0,1'b0},
        '{2'b00,1'b0,1'b0,2'b11,2'b00,5'd31,32'h0,        32'h7FFFFFFF, 32'h0,        1'b0,1'b0,1'b0,1'b0},
        '{2'b00,1'b0,1'b0,2'b00,2'b00,5'd7, 32'h0,        32'h12345678, 32'h12345678, 1'b0,1'b0,1'b0,1'b0},
        '{2'b00,1'b0,1'b1,2'b01,2'b00,5'd0, 32'hFFFFFFE3, 32'h1,        32'h8,        1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b1,1'b0,2'b00,2'b00,5'd0, 32'h1,        32'h2,        32'h1,        1'b0,1'b0,1'b0,1'b0},
        '{2'b01,1'b1,1'b0,2'b00,2'b00,5'd0, 32'h80000000, 32'h1,        32'h0,        1'b1,1'b0,1'b1,1'b1},
        '{2'b01,1'b0,1'b0,2'b00,2'b00,5'd0, 32'h7FFFFFFF, 32'h1,        32'h1,        1'b1,1'b0,1'b1,1'b0}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] cls, input logic sub, input logic src,
                         input logic [1:0] sop, input logic [1:0] lop,
                         input logic [4:0] imm, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        fn_class = cls; sub_en = sub; shamt_src = src; shift_op = sop;
        logic_op = lop; imm_shamt = imm; opnd_a = a; opnd_b = b;
        @(negedge clk);  // one rising edge has registered the result
    endtask

    function automatic string tag_of(input logic [1:0] cls, input logic src);
        if (cls == 2'b00) return src ? "R4" : "R3";
        if (cls == 2'b01) return "R6";
        if (cls == 2'b10) return "R5";
        return "R2";
    endfunction

    // operator-level reference (R1, R5, R7, R8)
    task automatic model(input logic [1:0] cls, input logic sub, input logic src,
                         input logic [1:0] sop, input logic [1:0] lop, input logic [4:0] imm,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] y, output logic z, output logic v, output logic c);
        logic [31:0] bb;
        logic [32:0] s;
        logic [4:0]  n;
        bb = sub ? ~b : b;
        s  = {1'b0, a} + {1'b0, bb} + {32'd0, sub};
        z  = (s[31:0] == 32'd0);
        c  = s[32];
        v  = (a[31] == bb[31]) && (s[31] != a[31]);
        n  = src ? a[4:0] : imm;
        case (cls)
            2'b00: case (sop)
                       2'b00: y = b;
                       2'b01: y = b << n;
                       2'b10: y = b >> n;
                       default: y = $unsigned($signed(b) >>> n);
                   endcase
            2'b01: y = {31'd0, s[31]};
            2'b10: y = s[31:0];
            default: case (lop)
                       2'b00: y = a & b;
                       2'b01: y = a | b;
                       2'b10: y = a ^ b;
                       default: y = ~(a | b);
                   endcase
        endcase
    endtask

    initial begin
        #(200000 * 5.0);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] ey;
        logic ez, ev, ec;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", "reset result", result, 32'd0);
        check("R9", "reset flags", {29'd0, zero_flag, ovf_flag, carry_out}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cls, VECS[i].sub, VECS[i].src, VECS[i].sop, VECS[i].lop,
                  VECS[i].imm, VECS[i].a, VECS[i].b);
            check(tag_of(VECS[i].cls, VECS[i].src), $sformatf("vector %0d result", i),
                  result, VECS[i].exp_y);
            if (VECS[i].chk_f)
                check(VECS[i].cls == 2'b10 ? "R8" : "R10", $sformatf("vector %0d flags", i),
                      {29'd0, zero_flag, ovf_flag, carry_out},
                      {29'd0, VECS[i].exp_z, VECS[i].exp_v, VECS[i].exp_c});
        end

        // R3: zero count leaves value for every shift operation
        for (int s = 0; s < 4; s++) begin
            drive(2'b00, 1'b0, 1'b0, 2'(s), 2'b00, 5'd0, 32'h0, 32'hA5C3_0F81);
            check("R3", $sformatf("zero count op %0d", s), result, 32'hA5C3_0F81);
        end

        // R4: variable count ignores immediate; constant count ignores opnd_a
        drive(2'b00, 1'b0, 1'b1, 2'b10, 2'b00, 5'd1, 32'h0000_0010, 32'hFFFF_0000);
        check("R4", "variable count 16", result, 32'h0000_FFFF);
        drive(2'b00, 1'b0, 1'b0, 2'b10, 2'b00, 5'd1, 32'h0000_0010, 32'hFFFF_0000);
        check("R4", "constant count 1", result, 32'h7FFF_8000);

        // R1/R7/R8: random sweep against the reference
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra, rb;
            logic [1:0]  rc, rs, rl;
            logic        rsub, rsrc;
            logic [4:0]  ri;
            ra = $urandom; rb = $urandom;
            if (k % 8 == 1) rb = ra;
            if (k % 8 == 2) ra = 32'h7FFFFFFF;
            if (k % 8 == 3) rb = 32'h80000000;
            rc = 2'($urandom); rs = 2'($urandom); rl = 2'($urandom);
            rsub = 1'($urandom); rsrc = 1'($urandom); ri = 5'($urandom);
            drive(rc, rsub, rsrc, rs, rl, ri, ra, rb);
            model(rc, rsub, rsrc, rs, rl, ri, ra, rb, ey, ez, ev, ec);
            check("R1", $sformatf("random %0d result", k), result, ey);
            check("R7", $sformatf("random %0d zero", k), {31'd0, zero_flag}, {31'd0, ez});
            check("R8", $sformatf("random %0d ovf/carry", k),
                  {30'd0, ovf_flag, carry_out}, {30'd0, ev, ec});
        end

        // R9: mid-run reset clears a nonzero result
        drive(2'b11, 1'b1, 1'b0, 2'b00, 2'b11, 5'd0, 32'h1, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9", "mid-run reset result", result, 32'd0);
        check("R9", "mid-run reset flags", {29'd0, zero_flag, ovf_flag, carry_out}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule